// File: doc/BRIEF.md
# DDR3 Command Decoder with Bank State Tracker

This block sits on the command/address side of a DDR3 memory device model or protocol monitor. Each clock it takes the sampled control pins: the clock-enable level from this cycle and the one before, chip select, the three strobe lines, the bank number and the 14-bit address. From these it produces one decoded command word, together with the bank, row, column, auto-precharge and burst-chop fields that belong to that command.

Alongside the decode it keeps, for each of the eight banks, whether a row is open and which row that is. The stored state is used in two ways. A column access reports the row it lands in. A command that does not fit the bank's state (an access to a closed bank, or an activate to a bank that is already open) is flagged as illegal and leaves the state alone. Timing between commands, data transfer and mode-register contents are outside this block.

Every decoded field is registered. Pins sampled at a rising edge appear on the outputs just after that same edge, and the bank state changes at that edge too.

Top module: `cmd_bank_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, all banks read as closed (`bankOpen` = 0) and the command code is 0 (deselect), with all fields and flags at zero.
- R2: With both CKE levels high and `csN` high, the command decodes as deselect (code 0) whatever the other pins are, and no bank state changes.
- R3: With `csN`=0, `rasN`=0, `casN`=1 and `weN`=1, the command is Activate (code 2). On a closed bank it sets that bank's bit in `bankOpen`, stores the row `addr[13:0]`, and reports that row on `cmdRow`.
- R4: `rasN`=0, `casN`=1, `weN`=0 is a precharge. With `addr[10]`=0 it is code 3 and closes only bank `bankAddr`. With `addr[10]`=1 it is code 4 and closes every bank.
- R5: `rasN`=1, `casN`=0 is a column access: `weN`=1 gives read (code 5) and `weN`=0 gives write (code 6). `cmdCol` carries `addr[9:0]` and `cmdRow` carries the row open in the addressed bank.
- R6: On a read or write, `autoPre` equals `addr[10]` and `burstChop` is the inverse of `addr[12]` (chop to 4 when `addr[12]`=0, burst of 8 when it is 1). Both flags are 0 for every other command.
- R7: A legal read or write with `addr[10]`=1 closes its bank at the same edge at which the access is decoded. A further access to that bank is then illegal.
- R8: With both CKE levels high and `csN`=0, the encodings decode as follows: all three strobes high is NOP (code 1); all low is mode-register set (code 7); `rasN`=0, `casN`=0, `weN`=1 is refresh (code 8); `rasN`=1, `casN`=1, `weN`=0 is ZQ calibration, long form (code 12) when `addr[10]`=1 and short form (code 13) when it is 0.
- R9: With the previous CKE high and the current CKE low, the refresh encoding decodes as self-refresh entry (code 9), and NOP or deselect decodes as power-down entry (code 10). A previous CKE low with the current one high is an exit (code 11) whatever the pins are. Both levels low is a low-power hold (code 14).
- R10: A read or write to a closed bank, or an Activate to an open bank, sets `illegal`. Bank state and stored rows are unchanged, and `cmdRow` reads 0 for the rejected command.
- R11: A falling CKE with any encoding other than refresh, NOP or deselect decodes as code 15 with `illegal` set, and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low reset; closes all banks |
| ckePrev | input | 1 | Clock-enable level sampled one cycle earlier |
| ckeCur | input | 1 | Clock-enable level this cycle |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 3 | Bank number |
| addr | input | 14 | Address / row / column bits, bit 10 and bit 12 also qualify commands |
| cmdCode | output | 4 | Decoded command code (see requirements) |
| cmdBank | output | 3 | Bank of an activate, precharge or access; 0 otherwise |
| cmdRow | output | 14 | Row opened by an activate or hit by an access; 0 otherwise |
| cmdCol | output | 10 | Column of an access; 0 otherwise |
| autoPre | output | 1 | Access requests auto-precharge |
| burstChop | output | 1 | Access is chopped to four beats |
| illegal | output | 1 | Command does not fit the bank state or CKE context |
| bankOpen | output | 8 | One bit per bank, set while a row is open |

## Verification
The access decode and the bank close can land on the same edge. A read with auto-precharge must report the row that was open, and in the same output cycle show its bank bit already cleared. The bench opens a bank and then issues a read with bit 10 set. It checks the reported row, the column and the cleared `bankOpen` bit together. A write to the same bank right after must then come back illegal. Illegal detection and state update also fall together: the bench issues an activate to an open bank and expects the flag with the stored row intact. A later read must still report the row that was first opened.

// File: rtl/cmdtrk_pkg.sv
package cmdtrk_pkg;

  // Address bit positions that qualify commands (fixed by the command set).
  localparam int AP_BIT = 10;
  localparam int BC_BIT = 12;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_PRE    = 4'd3,
    CMD_PREA   = 4'd4,
    CMD_RD     = 4'd5,
    CMD_WR     = 4'd6,
    CMD_MRS    = 4'd7,
    CMD_REF    = 4'd8,
    CMD_SRE    = 4'd9,
    CMD_PDE    = 4'd10,
    CMD_EXIT   = 4'd11,
    CMD_ZQL    = 4'd12,
    CMD_ZQS    = 4'd13,
    CMD_SLEEP  = 4'd14,
    CMD_BADCKE = 4'd15
  } cmd_e;

  // Strobes from the decoder to the bank table.
  typedef struct packed {
    logic openStb;
    logic closeOne;
    logic closeAll;
  } bank_strb_t;

endpackage

// File: rtl/bank_table.sv
module bank_table
  import cmdtrk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bank_strb_t           strb,
  input  logic [BANK_W-1:0]    selBank,
  input  logic [ROW_W-1:0]     newRow,
  output logic [NUM_BANKS-1:0] openVec,
  output logic [ROW_W-1:0]     selRow
);

  logic [ROW_W-1:0] rowMem [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (selBank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        openVec[b] <= 1'b0;
        rowMem[b]  <= '0;
      end else if (strb.closeAll) begin
        openVec[b] <= 1'b0;
      end else if (strb.closeOne && hit) begin
        openVec[b] <= 1'b0;
      end else if (strb.openStb && hit) begin
        openVec[b] <= 1'b1;
        rowMem[b]  <= newRow;
      end
    end
  end

  assign selRow = rowMem[selBank];

  // R4: a close-all leaves no bank open
  p_close_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.closeAll |=> (openVec == '0));

  // R3: an open strobe leaves the selected bank open
  p_open_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.openStb && !strb.closeAll && !strb.closeOne) |=> openVec[$past(selBank)]);

  // R7: a single-bank close (precharge or auto-precharge) clears that bank
  p_close_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.closeOne |=> !openVec[$past(selBank)]);

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdtrk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ckePrev,
  input  logic                 ckeCur,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [ROW_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0] openVec,
  input  logic [ROW_W-1:0]     selRow,
  output bank_strb_t           strb,
  output cmd_e                 cmdQ,
  output logic [BANK_W-1:0]    bankQ,
  output logic [ROW_W-1:0]     rowQ,
  output logic [COL_W-1:0]     colQ,
  output logic                 apQ,
  output logic                 bcQ,
  output logic                 illQ
);

  logic [2:0] strobes;
  logic       isNop, isRef, bankIsOpen, isAccess, usesBank, bad;
  cmd_e       cmd;

  assign strobes    = {rasN, casN, weN};
  assign isNop      = csN || (strobes == 3'b111);
  assign isRef      = !csN && (strobes == 3'b001);
  assign bankIsOpen = openVec[bankAddr];

  always_comb begin
    cmd = CMD_DESEL;
    unique case ({ckePrev, ckeCur})
      2'b00: cmd = CMD_SLEEP;
      2'b01: cmd = CMD_EXIT;
      2'b10: begin
        if (isNop)      cmd = CMD_PDE;
        else if (isRef) cmd = CMD_SRE;
        else            cmd = CMD_BADCKE;
      end
      default: begin
        if (csN) cmd = CMD_DESEL;
        else begin
          unique case (strobes)
            3'b111: cmd = CMD_NOP;
            3'b011: cmd = CMD_ACT;
            3'b010: cmd = addr[AP_BIT] ? CMD_PREA : CMD_PRE;
            3'b101: cmd = CMD_RD;
            3'b100: cmd = CMD_WR;
            3'b000: cmd = CMD_MRS;
            3'b001: cmd = CMD_REF;
            default: cmd = addr[AP_BIT] ? CMD_ZQL : CMD_ZQS;
          endcase
        end
      end
    endcase
  end

  assign isAccess = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign usesBank = isAccess || (cmd == CMD_ACT) || (cmd == CMD_PRE);

  always_comb begin
    bad = 1'b0;
    if (cmd == CMD_BADCKE)               bad = 1'b1;
    else if (cmd == CMD_ACT && bankIsOpen) bad = 1'b1;
    else if (isAccess && !bankIsOpen)     bad = 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.openStb  = (cmd == CMD_ACT) && !bad;
    strb.closeAll = (cmd == CMD_PREA);
    strb.closeOne = (cmd == CMD_PRE) || (isAccess && !bad && addr[AP_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdQ  <= CMD_DESEL;
      bankQ <= '0;
      rowQ  <= '0;
      colQ  <= '0;
      apQ   <= 1'b0;
      bcQ   <= 1'b0;
      illQ  <= 1'b0;
    end else begin
      cmdQ  <= cmd;
      bankQ <= usesBank ? bankAddr : '0;
      if (cmd == CMD_ACT && !bad)   rowQ <= addr;
      else if (isAccess && !bad)    rowQ <= selRow;
      else                          rowQ <= '0;
      colQ  <= isAccess ? addr[COL_W-1:0] : '0;
      apQ   <= isAccess && addr[AP_BIT];
      bcQ   <= isAccess && !addr[BC_BIT];
      illQ  <= bad;
    end
  end

  // R10: a rejected command leaves the bank state as it was
  p_illegal_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illQ |-> (openVec == $past(openVec)));

  // R2: chip select high with CKE held high yields deselect
  p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ckePrev && ckeCur && csN) |=> (cmdQ == CMD_DESEL));

  // R6: access qualifiers appear only on reads and writes
  p_flags_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (apQ || bcQ) |-> (cmdQ == CMD_RD || cmdQ == CMD_WR));

  // R9: a rising CKE is an exit whatever the pins say
  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ckePrev && ckeCur) |=> (cmdQ == CMD_EXIT));

endmodule

// File: rtl/cmd_bank_decoder.sv
module cmd_bank_decoder
  import cmdtrk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ckePrev,
  input  logic                 ckeCur,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    bankAddr,
  input  logic [ROW_W-1:0]     addr,
  output logic [3:0]           cmdCode,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [ROW_W-1:0]     cmdRow,
  output logic [COL_W-1:0]     cmdCol,
  output logic                 autoPre,
  output logic                 burstChop,
  output logic                 illegal,
  output logic [NUM_BANKS-1:0] bankOpen
);

  bank_strb_t       strb;
  logic [ROW_W-1:0] selRow;
  cmd_e             cmdQ;

  cmd_decode #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ckePrev(ckePrev), .ckeCur(ckeCur),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .addr(addr),
    .openVec(bankOpen), .selRow(selRow),
    .strb(strb),
    .cmdQ(cmdQ), .bankQ(cmdBank), .rowQ(cmdRow), .colQ(cmdCol),
    .apQ(autoPre), .bcQ(burstChop), .illQ(illegal)
  );

  bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .selBank(bankAddr), .newRow(addr),
    .openVec(bankOpen), .selRow(selRow)
  );

  assign cmdCode = cmdQ;

endmodule

// File: tb/cmd_bank_decoder_test.sv
module cmd_bank_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ckePrev = 1, ckeCur = 1, csN = 1, rasN = 1, casN = 1, weN = 1;
  logic [2:0]  bankAddr = 0;
  logic [13:0] addr = 0;
  logic [3:0]  cmdCode;
  logic [2:0]  cmdBank;
  logic [13:0] cmdRow;
  logic [9:0]  cmdCol;
  logic autoPre, burstChop, illegal;
  logic [7:0] bankOpen;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_bank_decoder uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive pins away from the edge, let one rising edge sample them, look just after.
  task automatic issue(bit cp, bit cc, bit cs, bit r, bit c, bit w,
                       logic [2:0] ba, logic [13:0] a);
    @(negedge clk);
    ckePrev = cp; ckeCur = cc; csN = cs; rasN = r; casN = c; weN = w;
    bankAddr = ba; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic act(logic [2:0] ba, logic [13:0] row);
    issue(1,1,0,0,1,1, ba, row);
  endtask

  task automatic t_reset;
    chk("R1 code", cmdCode, 0);
    chk("R1 banks", bankOpen, 0);
    chk("R1 flags", {illegal, autoPre, burstChop}, 0);
  endtask

  task automatic t_activate;
    act(3'd2, 14'h1234);
    chk("R3 code", cmdCode, 2);
    chk("R3 bank", cmdBank, 2);
    chk("R3 row", cmdRow, 14'h1234);
    chk("R3 open", bankOpen, 8'h04);
  endtask

  task automatic t_deselect;
    issue(1,1,1,0,1,1, 3'd5, 14'h0777);
    chk("R2 code", cmdCode, 0);
    chk("R2 banks", bankOpen, 8'h04);
  endtask

  task automatic t_access;
    issue(1,1,0,1,0,1, 3'd2, 14'h1000 | 14'h02A5);
    chk("R5 read code", cmdCode, 5);
    chk("R5 col", cmdCol, 10'h2A5);
    chk("R5 row", cmdRow, 14'h1234);
    chk("R6 bl8 no ap", {autoPre, burstChop}, 0);
    issue(1,1,0,1,0,0, 3'd2, 14'h0011);
    chk("R5 write code", cmdCode, 6);
    chk("R6 chop", burstChop, 1);
    chk("R6 col", cmdCol, 10'h011);
  endtask

  task automatic t_illegal;
    issue(1,1,0,1,0,1, 3'd3, 14'h1000);
    chk("R10 rd closed flag", illegal, 1);
    chk("R10 rd closed row", cmdRow, 0);
    chk("R10 banks", bankOpen, 8'h04);
    act(3'd2, 14'h0BAD);
    chk("R10 act open flag", illegal, 1);
    issue(1,1,0,1,0,1, 3'd2, 14'h1000);
    chk("R10 row kept", cmdRow, 14'h1234);
    chk("R10 legal again", illegal, 0);
  endtask

  task automatic t_autopre;
    act(3'd6, 14'h0F0F);
    chk("R3 open b6", bankOpen, 8'h44);
    issue(1,1,0,1,0,1, 3'd6, 14'h1400 | 14'h0003);
    chk("R7 ap flag", autoPre, 1);
    chk("R7 row", cmdRow, 14'h0F0F);
    chk("R7 closed same edge", bankOpen, 8'h04);
    issue(1,1,0,1,0,0, 3'd6, 14'h1000);
    chk("R7 later access illegal", illegal, 1);
  endtask

  task automatic t_precharge;
    act(3'd0, 14'h0001);
    act(3'd1, 14'h0002);
    chk("R3 three open", bankOpen, 8'h07);
    issue(1,1,0,0,1,0, 3'd0, 14'h0000);
    chk("R4 pre code", cmdCode, 3);
    chk("R4 one closed", bankOpen, 8'h06);
    issue(1,1,0,0,1,0, 3'd1, 14'h0400);
    chk("R4 prea code", cmdCode, 4);
    chk("R4 all closed", bankOpen, 0);
  endtask

  task automatic t_misc;
    issue(1,1,0,1,1,1, 3'd0, 0);
    chk("R8 nop", cmdCode, 1);
    issue(1,1,0,0,0,0, 3'd0, 0);
    chk("R8 mrs", cmdCode, 7);
    issue(1,1,0,0,0,1, 3'd0, 0);
    chk("R8 ref", cmdCode, 8);
    issue(1,1,0,1,1,0, 3'd0, 14'h0400);
    chk("R8 zq long", cmdCode, 12);
    issue(1,1,0,1,1,0, 3'd0, 14'h0000);
    chk("R8 zq short", cmdCode, 13);
  endtask

  task automatic t_cke;
    issue(1,0,0,0,0,1, 3'd0, 0);
    chk("R9 self refresh entry", cmdCode, 9);
    issue(1,0,1,0,0,0, 3'd0, 0);
    chk("R9 power-down entry", cmdCode, 10);
    issue(0,0,0,0,1,1, 3'd0, 0);
    chk("R9 hold", cmdCode, 14);
    issue(0,1,0,0,1,1, 3'd0, 0);
    chk("R9 exit", cmdCode, 11);
    issue(1,0,0,0,1,1, 3'd5, 14'h0055);
    chk("R11 code", cmdCode, 15);
    chk("R11 flag", illegal, 1);
    chk("R11 banks", bankOpen, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset;
    t_activate;
    t_deselect;
    t_access;
    t_illegal;
    t_autopre;
    t_precharge;
    t_misc;
    t_cke;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule